// File: doc/BRIEF.md
# Pulse Accumulator Counter

This block is an 8-bit counter that is fed by one external input line. It has two modes. In event mode it counts transitions of the line in one chosen direction. In gated mode it counts pulses of a periodic time-base tick, but only while the line is away from its blocking level. That second mode measures how long the line stays in one state.

A host reaches the block through a small synchronous register port, where a write completes in one cycle and a read is combinational. Address 0 is the count. Address 1 holds control. Address 2 holds the flags. Address 3 reads as zero and ignores writes.

- Control bits: bit 0 enables counting, bit 1 selects gated mode, bit 2 is the polarity bit, bit 3 enables the overflow interrupt, and bit 4 enables the line-edge interrupt.
- Flag bits: bit 5 is the overflow flag and bit 4 is the line-edge flag. Both flags are cleared by writing a 1 to their bit.

The external line passes through two synchronizing flops before any decision is made on it.

Top module: `pulse_accum`

## Requirements
- R1: Writing address 0 loads the 8-bit count on the next clock edge. A read of address 0 always returns the count as it stands.
- R2: Reset clears the control and flag registers and drops `irq`. Reset leaves the count holding the value it had before reset.
- R3: In event mode (control bit 1 = 0), each counted edge advances the count by one, by the third rising clock edge after the line changes. With polarity 0 the counted edge is falling. With polarity 1 it is rising. The opposite edge changes nothing.
- R4: In gated mode (control bit 1 = 1), the count advances once on each clock where `tick` is high and the synchronized line is away from its blocking level. With polarity 0 a low line blocks counting. With polarity 1 a high line blocks counting.
- R5: While control bit 0 is clear, the count never advances and the line-edge flag is never set.
- R6: An advance from 0xFF to 0x00 sets the overflow flag, which is bit 5 of address 2.
- R7: Writing 1 to flag bit 5 or bit 4 clears that flag. Writing 0 leaves it as it was. If a set and a clear arrive in the same cycle, the set wins.
- R8: When enabled, the line-edge flag (bit 4 of address 2) is set on every counted edge in event mode. In gated mode it is set on the edge that closes the gate: falling for polarity 0, rising for polarity 1.
- R9: A host write to the count in the same cycle as an advance takes priority. The written value is loaded, and no overflow is flagged.
- R10: `irq` is high exactly while (overflow flag and control bit 3) or (line-edge flag and control bit 4).
- R11: Address 1 reads back control bits 4..0 as written, with bits 7..5 reading zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin | input | 1 | External line, asynchronous to `clk` |
| tick | input | 1 | Time-base pulse, one clock wide, used in gated mode |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume three things about the inputs. First, `tick` and the host port are synchronous to `clk`. Second, `wdata` is valid whenever `wr` is high. Third, the count has been written at least once before anything checks its value, because reset does not initialize the count.

The stimulus respects all three. It drives every input on the falling clock edge, and it loads the count before it enables counting. The bench keeps `pin` high or low for at least one full clock. As a result, the behavioural model's three-sample history matches the synchronizer exactly, with no dependence on metastability.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          tick,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CNT = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);
  localparam logic [AW-1:0] A_FLG = AW'(2);
  localparam int B_OVF = 5;
  localparam int B_EDG = 4;

  logic [W-1:0] cnt_q;
  logic [4:0]   ctl_q;
  logic         ovf_q, edg_q;
  logic         s1, s2, s3;

  wire en_q   = ctl_q[0];
  wire mode_q = ctl_q[1];
  wire pol_q  = ctl_q[2];
  wire oie_q  = ctl_q[3];
  wire eie_q  = ctl_q[4];

  wire cnt_wr = wr && addr == A_CNT;
  wire ctl_wr = wr && addr == A_CTL;
  wire flg_wr = wr && addr == A_FLG;

  wire rise   = s2 & ~s3;
  wire fall   = ~s2 & s3;
  wire ev     = pol_q ? rise : fall;
  wire open_g = s2 ^ pol_q;
  wire bump   = en_q & (mode_q ? (tick & open_g) : ev);
  wire wrap   = bump & ~cnt_wr & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {pin, s1, s2};

  always_ff @(posedge clk)
    if (cnt_wr)    cnt_q <= wdata;
    else if (bump) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wdata[4:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_q <= 1'b0;
      edg_q <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~(flg_wr & wdata[B_OVF])) | wrap;
      edg_q <= (edg_q & ~(flg_wr & wdata[B_EDG])) | (en_q & ev);
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT: rdata = cnt_q;
      A_CTL: rdata[4:0] = ctl_q;
      A_FLG: begin
        rdata[B_OVF] = ovf_q;
        rdata[B_EDG] = edg_q;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = (ovf_q & oie_q) | (edg_q & eie_q);

  // R6
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !cnt_wr && cnt_q == {W{1'b1}}) |=> (cnt_q == '0 && ovf_q));

  // R9
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  // R4
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q && s2 == pol_q && !cnt_wr) |=> $stable(cnt_q));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_wr && wdata[B_OVF] && !bump) |=> !ovf_q);
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pin = 0, tick = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq;

  always #4 clk = ~clk;

  pulse_accum dut (.clk(clk), .rst_n(rst_n), .pin(pin), .tick(tick), .wr(wr),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R2";

  int  m_cnt = 0;
  bit  m_known = 0;
  bit  m_en, m_mode, m_pol, m_oie, m_eie, m_ovf, m_edg;
  bit  h [3];
  int  rot = 0;

  always @(posedge clk) begin
    bit s2, s3, ev, inc, wrap;
    if (!rst_n) begin
      {m_en, m_mode, m_pol, m_oie, m_eie, m_ovf, m_edg} = '0;
      h = '{0, 0, 0};
    end else begin
      s2 = h[1]; s3 = h[2];
      ev  = m_pol ? (s2 && !s3) : (!s2 && s3);
      inc = m_en && (m_mode ? (tick && (s2 != m_pol)) : ev);
      wrap = 0;
      if (wr && addr == 0) begin m_cnt = wdata; m_known = 1; end
      else if (inc) begin
        if (m_cnt == 255) begin m_cnt = 0; wrap = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (wr && addr == 2) begin
        if (wdata[5]) m_ovf = 0;
        if (wdata[4]) m_edg = 0;
      end
      if (wrap) m_ovf = 1;
      if (m_en && ev) m_edg = 1;
      if (wr && addr == 1) {m_eie, m_oie, m_pol, m_mode, m_en} = wdata[4:0];
      h[2] = h[1]; h[1] = h[0]; h[0] = pin;
    end
  end

  function automatic logic [7:0] mread(input logic [1:0] a);
    case (a)
      2'd0: return 8'(m_cnt);
      2'd1: return {3'b0, m_eie, m_oie, m_pol, m_mode, m_en};
      2'd2: return {2'b0, m_ovf, m_edg, 4'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare();
    logic mirq;
    mirq = (m_ovf && m_oie) || (m_edg && m_eie);
    if (!(addr == 0 && !m_known)) begin
      checks++;
      if (rdata !== mread(addr)) begin
        fails++;
        $display("FAIL %s: rdata at addr %0d got %02h expected %02h", cur_req, addr, rdata, mread(addr));
      end
    end
    checks++;
    if (irq !== mirq) begin
      fails++;
      $display("FAIL R10 (%s): irq got %b expected %b", cur_req, irq, mirq);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      if (!wr) begin addr = 2'(rot % 3); rot++; end
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    step();
    wr = 0;
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      pin = ~pin; step(hi);
      pin = ~pin; step(lo);
    end
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0; step(gap);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    cur_req = "R2"; step(3);
    cur_req = "R1"; wreg(0, 8'h5A); step(4); wreg(0, 8'h00); step(3);
    cur_req = "R11"; wreg(1, 8'hFF); step(3); wreg(1, 8'h00); step(3);
    cur_req = "R3"; wreg(1, 8'h01); pin = 1; step(4); pin = 0; step(4);
    pulses(5, 3, 4); pulses(4, 1, 1);
    wreg(1, 8'h05); pulses(5, 2, 3); pulses(3, 6, 1);
    cur_req = "R8"; wreg(1, 8'h15); pulses(2, 3, 3); wreg(2, 8'h10); step(3);
    wreg(2, 8'h00); step(2);
    cur_req = "R5"; wreg(1, 8'h00); pulses(4, 2, 2); step(3);
    cur_req = "R6"; wreg(0, 8'hFD); wreg(1, 8'h09); pulses(5, 2, 2); step(3);
    cur_req = "R7"; wreg(2, 8'h00); step(2); wreg(2, 8'h20); step(3);
    wreg(0, 8'hFF);
    pin = ~pin; step(); pin = ~pin;
    for (int i = 0; i < 6; i++) wreg(2, 8'h30);
    step(3);
    cur_req = "R9"; wreg(0, 8'hFF); pin = ~pin; step(); pin = ~pin;
    for (int i = 0; i < 6; i++) wreg(0, 8'hFF);
    step(4); wreg(2, 8'h30);
    cur_req = "R4"; pin = 1; wreg(0, 8'h10); wreg(1, 8'h03); step(3);
    ticks(6, 2); pin = 0; step(3); ticks(4, 2);
    wreg(1, 8'h07); ticks(5, 3); pin = 1; step(3); ticks(4, 1);
    cur_req = "R8"; wreg(1, 8'h13); pin = 0; step(3); wreg(2, 8'h10);
    pin = 1; step(3); ticks(3, 1); pin = 0; step(4); wreg(2, 8'h30); step(2);
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      tick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) pin = ~pin;
      if (r < 5) wreg(1, 8'($urandom_range(0, 31)));
      else if (r < 9) wreg(2, 8'($urandom_range(0, 255)));
      else if (r < 11) wreg(0, 8'($urandom_range(240, 255)));
      else step();
    end
    tick = 0;
    cur_req = "R2"; wreg(0, 8'h33); wreg(1, 8'h00); step(2);
    rst_n = 0; step(3); rst_n = 1; step(4);
    done = 1;
    summary();
    $finish;
  end
endmodule